// File: doc/BRIEF.md
# Nibble-Serial Test Word Loader

This block builds a 16-bit test word from a stream of 8-bit characters, such as those coming off a paper-tape reader. Each character carries three control bits, four data bits and one parity bit. The control field chooses which four-bit slot of the word receives the data nibble. A reserved control code empties the word and starts assembly again. A character with bad parity stops all further loading and raises a flag that stays set until reset.

The word fills one slot at a time, from the least significant slot upward. When the fourth nibble lands, the finished word is compared with an expected value supplied at the port. A one-cycle done strobe then marks the result. The match flag keeps that result until the word is next emptied. A character that names a slot out of turn is dropped, and it raises a sequence-error flag.

Top module: `nl_loader`

## Requirements
- R1: A character is good only when its 8 bits hold an odd number of ones. Bit 7 is the parity bit, bits [6:4] are the control code and bits [3:0] are the data nibble.
- R2: A good character with control code k in 0..3 is accepted only when k equals the next free slot, so slots fill in the order 0, 1, 2, 3. Its nibble is written to word bits [4k+3:4k], so slot 0 is least significant. The new word shows on `word_out` after the clock edge that samples the character.
- R3: A good character with a slot code other than the next free slot sets `seq_err` and leaves the word unchanged. Once all four slots are full, every slot code counts as out of turn. `seq_err` stays set until a clear or a reset.
- R4: A character whose parity is wrong sets `par_err`, and `par_err` stays set until reset.
- R5: While `par_err` is set, every character is ignored, the clear code included. `word_out`, `seq_err`, `done` and `match` do not change.
- R6: On the edge that accepts the slot 3 character, `done` rises for exactly one cycle. At the same edge, `match` takes the result of comparing the completed word with `expect_word` as sampled on that edge.
- R7: Control code 7 clears `word_out`, the slot count, `seq_err` and `match` to zero. `match` holds its value from the time `done` fires until the next clear.
- R8: Control codes 4, 5 and 6 are ignored. They leave the word, the slot count and every flag unchanged.
- R9: While `rst_n` is low, and after it is released, `word_out`, `done`, `match`, `seq_err` and `par_err` are all zero, and the next free slot is 0.
- R10: When `char_valid` is low, `char_data` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | Qualifies `char_data` for one cycle |
| char_data | input | 8 | Incoming character: parity, control code, data nibble |
| expect_word | input | 16 | Known value the finished word is compared with |
| word_out | output | 16 | Assembled word |
| done | output | 1 | One-cycle strobe when the word is complete |
| match | output | 1 | Completed word equalled `expect_word`; holds until clear |
| seq_err | output | 1 | An out-of-turn slot code was seen |
| par_err | output | 1 | A parity error halted loading (sticky) |

## Verification
All results are registered, so every output responds exactly one clock edge after the character that caused it. The bench drives each character on a falling edge and holds it for one cycle. It reads the outputs on the next falling edge, which is the first sample point after the edge that takes the character.

`done` is checked high at that sample point and low one cycle later. `match` is checked again on that later sample to confirm that it holds. Ignored stimuli are judged the same way, one edge later: `word_out` and the flags must read the same as before the character was sent.

// File: rtl/nl_pkg.sv
package nl_pkg;

  // Decision taken for the character presented in the current cycle
  typedef enum logic [2:0] {
    ACT_IDLE  = 3'd0,  // no valid character, or loading halted
    ACT_LOAD  = 3'd1,  // nibble written into the next free slot
    ACT_CLEAR = 3'd2,  // word emptied, assembly restarts
    ACT_SEQ   = 3'd3,  // slot code out of turn
    ACT_PAR   = 3'd4,  // parity failure, halt
    ACT_SKIP  = 3'd5   // reserved code, no effect
  } nl_act_e;

endpackage

// File: rtl/nl_char_decode.sv
module nl_char_decode #(
  parameter int unsigned CTRL_W = 3,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned CHAR_W = 1 + CTRL_W + NIB_W
) (
  input  logic [CHAR_W-1:0] char_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [NIB_W-1:0]  nib_o,
  output logic              par_ok_o
);

  // Field split: parity on top, control code in the middle, nibble at the bottom
  always_comb begin
    nib_o    = char_i[NIB_W-1:0];
    ctrl_o   = char_i[NIB_W +: CTRL_W];
    par_ok_o = ^char_i;  // odd parity: the whole character has an odd count of ones
  end

endmodule

// File: rtl/nl_slot_seq.sv
module nl_slot_seq
  import nl_pkg::*;
#(
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned CTRL_W     = 3,
  parameter int unsigned CLEAR_CODE = 7,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              par_ok_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output nl_act_e           act_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              last_o,
  output logic              seq_err_o,
  output logic              par_err_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seq_q, seq_d;
  logic             par_q, par_d;
  logic             upd_en;
  nl_act_e          act;

  // Classify the character; parity is checked before the control code
  always_comb begin
    act = ACT_IDLE;
    if (valid_i && !par_q) begin
      if (!par_ok_i) begin
        act = ACT_PAR;
      end else if (int'(ctrl_i) == int'(CLEAR_CODE)) begin
        act = ACT_CLEAR;
      end else if (int'(ctrl_i) < int'(SLOTS)) begin
        if ((int'(cnt_q) < int'(SLOTS)) && (int'(ctrl_i) == int'(cnt_q))) begin
          act = ACT_LOAD;
        end else begin
          act = ACT_SEQ;
        end
      end else begin
        act = ACT_SKIP;
      end
    end
  end

  // Next state
  always_comb begin
    cnt_d = cnt_q;
    seq_d = seq_q;
    par_d = par_q;
    case (act)
      ACT_LOAD:  cnt_d = cnt_q + CNT_W'(1);
      ACT_CLEAR: begin
        cnt_d = '0;
        seq_d = 1'b0;
      end
      ACT_SEQ:   seq_d = 1'b1;
      ACT_PAR:   par_d = 1'b1;
      default:   ;
    endcase
  end

  assign upd_en = (act != ACT_IDLE) && (act != ACT_SKIP);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seq_q <= 1'b0;
      par_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      seq_q <= seq_d;
      par_q <= par_d;
    end
  end

  assign act_o     = act;
  assign slot_o    = ctrl_i[SLOT_W-1:0];
  assign last_o    = (act == ACT_LOAD) && (int'(cnt_q) == int'(SLOTS) - 1);
  assign seq_err_o = seq_q;
  assign par_err_o = par_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= int'(SLOTS)) else $error("slot count overran");  // R2

  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    par_q |=> par_q) else $error("parity flag dropped");  // R4

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    par_q |-> (act == ACT_IDLE)) else $error("character acted on while halted");  // R5

  AST_SEQ_HOLD_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_SEQ) |=> ($stable(cnt_q) && seq_q)) else $error("out-of-turn slot moved count");  // R3

endmodule

// File: rtl/nl_word_reg.sv
module nl_word_reg
  import nl_pkg::*;
#(
  parameter int unsigned NIB_W = 4,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned WORD_W = NIB_W * SLOTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nl_act_e           act_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] expect_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o,
  output logic              match_o
);

  logic [WORD_W-1:0] word_q, word_d;
  logic [SLOTS-1:0]  nib_en;
  logic              clr;
  logic              word_en;
  logic              done_q;
  logic              match_q, match_d;

  assign clr     = (act_i == ACT_CLEAR);
  assign word_en = clr || (act_i == ACT_LOAD);

  // One write-enable and one next-value mux per slot
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign nib_en[g] = (act_i == ACT_LOAD) && (int'(slot_i) == g);
    assign word_d[g*NIB_W +: NIB_W] = clr       ? '0 :
                                      nib_en[g] ? nib_i :
                                                  word_q[g*NIB_W +: NIB_W];
  end

  // Compare against the word as it stands after this edge
  always_comb begin
    match_d = match_q;
    if (clr) begin
      match_d = 1'b0;
    end else if (last_i) begin
      match_d = (word_d == expect_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      done_q  <= last_i;
      match_q <= match_d;
    end
  end

  assign word_o  = word_q;
  assign done_o  = done_q;
  assign match_o = match_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q) else $error("done longer than one cycle");  // R6

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((word_q == '0) && !match_q)) else $error("clear left state behind");  // R7

  AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !last_i) |=> $stable(match_q)) else $error("match moved without completion");  // R7

  AST_WORD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !word_en |=> $stable(word_q)) else $error("word moved on an ignored character");  // R8

endmodule

// File: rtl/nl_loader.sv
module nl_loader
  import nl_pkg::*;
#(
  parameter int unsigned NIB_W      = 4,
  parameter int unsigned SLOTS      = 4,
  parameter int unsigned CTRL_W     = 3,
  parameter int unsigned CLEAR_CODE = 7,
  localparam int unsigned CHAR_W = 1 + CTRL_W + NIB_W,
  localparam int unsigned WORD_W = NIB_W * SLOTS,
  localparam int unsigned SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [CHAR_W-1:0] char_data,
  input  logic [WORD_W-1:0] expect_word,
  output logic [WORD_W-1:0] word_out,
  output logic              done,
  output logic              match,
  output logic              seq_err,
  output logic              par_err
);

  logic [CTRL_W-1:0] ctrl;
  logic [NIB_W-1:0]  nib;
  logic              par_ok;
  nl_act_e           act;
  logic [SLOT_W-1:0] slot;
  logic              last;

  nl_char_decode #(.CTRL_W(CTRL_W), .NIB_W(NIB_W)) u_dec (
    .char_i   (char_data),
    .ctrl_o   (ctrl),
    .nib_o    (nib),
    .par_ok_o (par_ok)
  );

  nl_slot_seq #(.SLOTS(SLOTS), .CTRL_W(CTRL_W), .CLEAR_CODE(CLEAR_CODE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_i   (char_valid),
    .par_ok_i  (par_ok),
    .ctrl_i    (ctrl),
    .act_o     (act),
    .slot_o    (slot),
    .last_o    (last),
    .seq_err_o (seq_err),
    .par_err_o (par_err)
  );

  nl_word_reg #(.NIB_W(NIB_W), .SLOTS(SLOTS)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_i    (act),
    .slot_i   (slot),
    .nib_i    (nib),
    .last_i   (last),
    .expect_i (expect_word),
    .word_o   (word_out),
    .done_o   (done),
    .match_o  (match)
  );

  AST_VALID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |=> ($stable(word_out) && !done)) else $error("idle cycle changed output");  // R10

endmodule

// File: tb/nl_loader_tb.sv
module nl_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        char_valid;
  logic [7:0]  char_data;
  logic [15:0] expect_word;
  logic [15:0] word_out;
  logic        done, match, seq_err, par_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nl_loader u_dut (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .expect_word(expect_word), .word_out(word_out), .done(done), .match(match),
    .seq_err(seq_err), .par_err(par_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Build a character; odd parity unless bad is set (R1)
  function automatic logic [7:0] mk(input int c, input int n, input bit bad);
    logic [6:0] b;
    b = {c[2:0], n[3:0]};
    return {(~^b) ^ bad, b};
  endfunction

  task automatic send(input logic [7:0] c);
    @(negedge clk);
    char_valid = 1'b1;
    char_data  = c;
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic idle_garbage(input logic [7:0] c);
    @(negedge clk);
    char_data = c;
    char_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    char_valid = 1'b0;
    char_data = 8'h00;
    repeat (2) @(negedge clk);
    chk("R9 word in reset", {16'h0, word_out}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] w, e, part;
    expect_word = 16'h0;
    do_reset();
    chk("R9 word", {16'h0, word_out}, 32'h0);
    chk("R9 flags", {28'h0, done, match, seq_err, par_err}, 32'h0);

    // Sweep of words, matching and mismatching expected values
    for (int i = 0; i < 256; i++) begin
      w = 16'((i * 4099) ^ (i << 9));
      e = (i % 3 == 0) ? (w ^ 16'h0100) : w;
      expect_word = e;
      send(mk(7, i, 1'b0));
      chk("R7 clear word", {16'h0, word_out}, 32'h0);
      chk("R7 clear match", {31'h0, match}, 32'h0);
      part = 16'h0;
      for (int s = 0; s < 4; s++) begin
        send(mk(s, int'(w[s*4 +: 4]), 1'b0));
        part[s*4 +: 4] = w[s*4 +: 4];
        chk("R2 partial word", {16'h0, word_out}, {16'h0, part});
        chk("R6 done timing", {31'h0, done}, {31'h0, (s == 3)});
      end
      chk("R6 match", {31'h0, match}, {31'h0, (e == w)});
      idle_garbage(mk(0, 5, 1'b0));
      chk("R6 done one cycle", {31'h0, done}, 32'h0);
      chk("R7 match held", {31'h0, match}, {31'h0, (e == w)});
      chk("R10 invalid ignored", {16'h0, word_out}, {16'h0, w});
      expect_word = ~e;
      @(negedge clk);
      chk("R7 match held after expect change", {31'h0, match}, {31'h0, (e == w)});
    end

    // Out-of-turn slot codes
    send(mk(7, 0, 1'b0));
    send(mk(1, 4'hA, 1'b0));
    chk("R3 seq err set", {31'h0, seq_err}, 32'h1);
    chk("R3 word kept", {16'h0, word_out}, 32'h0);
    send(mk(0, 4'h3, 1'b0));
    chk("R3 seq err sticky", {31'h0, seq_err}, 32'h1);
    chk("R2 load after seq err", {16'h0, word_out}, 32'h3);
    send(mk(7, 0, 1'b0));
    chk("R7 clear seq err", {31'h0, seq_err}, 32'h0);
    for (int s = 0; s < 4; s++) send(mk(s, s + 1, 1'b0));
    chk("R2 full word", {16'h0, word_out}, 32'h4321);
    send(mk(0, 4'hF, 1'b0));
    chk("R3 slot after full", {31'h0, seq_err}, 32'h1);
    chk("R3 full word kept", {16'h0, word_out}, 32'h4321);
    chk("R3 no done", {31'h0, done}, 32'h0);

    // Reserved codes
    send(mk(7, 0, 1'b0));
    send(mk(0, 4'h9, 1'b0));
    for (int c = 4; c < 7; c++) begin
      send(mk(c, 4'hE, 1'b0));
      chk("R8 reserved word", {16'h0, word_out}, 32'h9);
      chk("R8 reserved flags", {30'h0, seq_err, par_err}, 32'h0);
    end
    send(mk(1, 4'h6, 1'b0));
    chk("R8 slot count kept", {16'h0, word_out}, 32'h69);

    // Parity: every nibble with both parities
    for (int n = 0; n < 16; n++) begin
      do_reset();
      send(mk(0, n, 1'b0));
      chk("R1 good parity loads", {16'h0, word_out}, n);
      chk("R1 good parity no flag", {31'h0, par_err}, 32'h0);
      send(mk(1, 15 - n, 1'b1));
      chk("R4 parity flag", {31'h0, par_err}, 32'h1);
      chk("R4 word kept", {16'h0, word_out}, n);
      send(mk(7, 0, 1'b0));
      chk("R5 clear ignored", {16'h0, word_out}, n);
      chk("R5 flag sticky", {31'h0, par_err}, 32'h1);
      send(mk(1, 2, 1'b0));
      send(mk(3, 2, 1'b0));
      chk("R5 halted word", {16'h0, word_out}, n);
      chk("R5 halted flags", {29'h0, done, match, seq_err}, 32'h0);
    end
    do_reset();
    chk("R9 parity cleared by reset", {31'h0, par_err}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule